// File: doc/BRIEF.md
# Multithreaded Stage Input Skid Buffer

This block sits at the input of one stage of an in-order pipeline that runs several hardware threads. It keeps a separate queue of instruction tags for each thread, where each tag holds a sequence number and a program counter. In every cycle it takes entries from the upstream stage's output latch. That latch has WIDTH slots, and each slot carries a thread number, a tag and a flag marking it as already squashed. The stage may already have filled some of its per-cycle width from its own entries, and the `local_cnt` input gives that number. The block accepts only as many live slots as the remaining width allows. Every further live slot is handed back through `pb_valid`, so the upstream stage can put it at the head of its own queue for that thread. When such a hand-back happens and the upstream thread is running or idle, the block raises a per-thread request that forces that thread into its unblocking state.

Entries can also come back from the next stage through the return port. These go to the head of a queue, ahead of the older contents. A squash names one thread and a sequence number. It removes every stored entry of that thread that is younger than the number, wherever the entry sits in the queue, and it filters anything arriving for that thread in the same cycle. Each thread also reports its free space and a send permission that takes the slots already waiting in the upstream latch into account.

Top module: `skid_stage_buffer`

## Requirements
- R1: After reset every thread queue is empty (`hd_valid` = 0), `free_cnt` is DEPTH for every thread, `send_ok` is 1 and `ovf_err` is 0.
- R2: A latch slot is live when `in_valid`=1 and `in_squashed`=0 and a same-cycle squash does not kill it. Live slots are taken in slot order, slot 0 first, up to a room of WIDTH minus `local_cnt` (0 if `local_cnt` is at least WIDTH). Each accepted slot is appended to the tail of its thread's queue, in slot order.
- R3: A slot with `in_squashed`=1 is discarded. It is never stored, never handed back, and uses none of the room.
- R4: A live slot beyond the room sees `pb_valid` for that slot go to 1 in the same cycle, and the slot is not stored. `pb_valid` is 0 for every other slot.
- R5: `up_unblock[t]` is 1 in a cycle exactly when some slot of thread t is handed back while `up_status[t]` is idle (2'd0) or running (2'd1). For blocked (2'd2) or unblocking (2'd3) it stays 0.
- R6: A squash (`sq_valid`, `sq_tid`, `sq_seq`) removes every stored entry of that thread whose unsigned sequence number is greater than `sq_seq`, at any position. The kept entries stay in their order with no gaps between them.
- R7: Within one cycle the squash comes first. Incoming latch slots and returned entries of the squashed thread that are younger than `sq_seq` are dropped, are not handed back, and use no room.
- R8: Returned entries (`ret_valid`) are placed at the head of their thread's queue, ahead of existing entries, with return slot 0 frontmost.
- R9: `pop_valid` removes the head entry of thread `pop_tid`, and this happens before any insertion in that cycle. A pop on an empty queue has no effect.
- R10: `free_cnt[t]` equals DEPTH minus the occupancy of thread t. `send_ok[t]` is 1 exactly when `free_cnt[t]` is greater than the number of slots with `in_valid`=1 for thread t.
- R11: If an update would take a queue past DEPTH, the newest entries beyond DEPTH are lost and `ovf_err` goes to 1. It stays at 1 until reset.
- R12: Operations on one thread never change another thread's queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | WIDTH | Upstream latch slot valid |
| in_squashed | input | WIDTH | Upstream latch slot already squashed |
| in_tid | input | WIDTH x TID_W | Slot thread number |
| in_seq | input | WIDTH x SEQ_W | Slot sequence number |
| in_pc | input | WIDTH x PC_W | Slot program counter |
| local_cnt | input | CNT_W | Width already used this cycle by the stage's own entries |
| ret_valid | input | WIDTH | Entries returned from the next stage |
| ret_tid | input | WIDTH x TID_W | Returned entry thread number |
| ret_seq | input | WIDTH x SEQ_W | Returned entry sequence number |
| ret_pc | input | WIDTH x PC_W | Returned entry program counter |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Squashed thread |
| sq_seq | input | SEQ_W | Squash sequence bound |
| pop_valid | input | 1 | Remove head entry |
| pop_tid | input | TID_W | Thread to pop |
| up_status | input | NUM_THREADS x 2 | Upstream per-thread status |
| pb_valid | output | WIDTH | Slot handed back to the upstream head |
| up_unblock | output | NUM_THREADS | Force upstream thread to unblocking |
| hd_valid | output | NUM_THREADS | Queue non-empty |
| hd_seq | output | NUM_THREADS x SEQ_W | Head sequence number |
| hd_pc | output | NUM_THREADS x PC_W | Head program counter |
| free_cnt | output | NUM_THREADS x OCC_W | Free entries per thread |
| send_ok | output | NUM_THREADS | Upstream may send to this thread |
| ovf_err | output | 1 | Sticky depth overflow |

## Verification
The hardest case to reach is a squash that must remove entries from the middle of a queue while older entries stay on both sides. Tail insertion alone only gives rising sequence numbers. The bench therefore builds a thread queue whose sequence numbers are deliberately out of order (10, 13, 4, 15), squashes between them, and then drains the queue with pops, so the order of the kept entries can be seen at the head port. A second hard case is the same-cycle collision of a squash, a latch slot and a returned entry for one thread under a reduced room. The bench drives all three in one cycle, then checks that the killed slot is neither stored nor handed back and that the surviving slot still fits in the room.

// File: rtl/skid_pkg.sv
package skid_pkg;

    localparam int SEQ_W = 8;
    localparam int PC_W  = 16;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
    } tag_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_BLOCKED  = 2'd2,
        ST_UNBLOCK  = 2'd3
    } stage_st_e;

    function automatic logic is_younger(input logic [SEQ_W-1:0] seq,
                                        input logic [SEQ_W-1:0] bound);
        return seq > bound;
    endfunction

    function automatic logic may_unblock(input logic [1:0] st);
        return (st == ST_RUN) || (st == ST_IDLE);
    endfunction

endpackage

// File: rtl/skid_sorter.sv
module skid_sorter
    import skid_pkg::*;
#(
    parameter int WIDTH = 2,
    parameter int TID_W = 1,
    parameter int CNT_W = 2
) (
    input  logic [WIDTH-1:0]            in_valid,
    input  logic [WIDTH-1:0]            in_squashed,
    input  logic [WIDTH-1:0][TID_W-1:0] in_tid,
    input  logic [WIDTH-1:0][SEQ_W-1:0] in_seq,
    input  logic [CNT_W-1:0]            local_cnt,
    input  logic                        sq_valid,
    input  logic [TID_W-1:0]            sq_tid,
    input  logic [SEQ_W-1:0]            sq_seq,
    output logic [WIDTH-1:0]            acc,
    output logic [WIDTH-1:0]            pb
);

    always_comb begin
        int   room;
        int   rank;
        logic kill;
        logic live;
        room = (int'(local_cnt) >= WIDTH) ? 0 : WIDTH - int'(local_cnt);
        rank = 0;
        for (int i = 0; i < WIDTH; i++) begin
            kill   = sq_valid && (in_tid[i] == sq_tid) && is_younger(in_seq[i], sq_seq);
            live   = in_valid[i] && !in_squashed[i] && !kill;
            acc[i] = live && (rank < room);
            pb[i]  = live && (rank >= room);
            if (live) rank++;
        end
    end

endmodule

// File: rtl/skid_deque.sv
module skid_deque
    import skid_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 2,
    parameter int OCC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             sq_hit,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic [WIDTH-1:0] ret_mask,
    input  tag_t             ret_tag  [WIDTH],
    input  logic [WIDTH-1:0] tail_mask,
    input  tag_t             tail_tag [WIDTH],
    output tag_t             head,
    output logic             head_valid,
    output logic [OCC_W-1:0] occ,
    output logic             ovf
);

    localparam int LW    = DEPTH + 2 * WIDTH;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tag_t             mem   [DEPTH];
    tag_t             mem_n [DEPTH];
    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] occ_n;
    logic [LW-1:0]    cand_v;
    tag_t             cand_t [LW];

    // Candidate order: returned entries, surviving stored entries, new tail entries
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            cand_v[i] = ret_mask[i] && !(sq_hit && is_younger(ret_tag[i].seq, sq_seq));
            cand_t[i] = ret_tag[i];
        end
        for (int i = 0; i < DEPTH; i++) begin
            cand_v[WIDTH+i] = (i < int'(occ_q)) && !(pop && i == 0)
                              && !(sq_hit && is_younger(mem[i].seq, sq_seq));
            cand_t[WIDTH+i] = mem[i];
        end
        for (int i = 0; i < WIDTH; i++) begin
            cand_v[WIDTH+DEPTH+i] = tail_mask[i] && !(sq_hit && is_younger(tail_tag[i].seq, sq_seq));
            cand_t[WIDTH+DEPTH+i] = tail_tag[i];
        end
    end

    // Compaction into the storage, oldest candidates first
    always_comb begin
        int n;
        mem_n = mem;
        n = 0;
        for (int k = 0; k < LW; k++) begin
            if (cand_v[k]) begin
                if (n < DEPTH) mem_n[n[IDX_W-1:0]] = cand_t[k];
                n++;
            end
        end
        occ_n = (n > DEPTH) ? OCC_W'(DEPTH) : OCC_W'(n);
        ovf   = (n > DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else     occ_q <= occ_n;
    end

    always_ff @(posedge clk) begin
        mem <= mem_n;
    end

    assign head       = mem[0];
    assign head_valid = (occ_q != '0);
    assign occ        = occ_q;

endmodule

// File: rtl/skid_credit.sv
module skid_credit #(
    parameter int NUM_THREADS = 2,
    parameter int DEPTH       = 4,
    parameter int WIDTH       = 2,
    parameter int TID_W       = 1,
    parameter int OCC_W       = 3
) (
    input  logic [NUM_THREADS-1:0][OCC_W-1:0] occ,
    input  logic [WIDTH-1:0]                  in_valid,
    input  logic [WIDTH-1:0][TID_W-1:0]       in_tid,
    output logic [NUM_THREADS-1:0][OCC_W-1:0] free_cnt,
    output logic [NUM_THREADS-1:0]            send_ok
);

    always_comb begin
        int waiting;
        for (int t = 0; t < NUM_THREADS; t++) begin
            free_cnt[t] = OCC_W'(DEPTH) - occ[t];
            waiting = 0;
            for (int i = 0; i < WIDTH; i++) begin
                if (in_valid[i] && int'(in_tid[i]) == t) waiting++;
            end
            send_ok[t] = int'(free_cnt[t]) > waiting;
        end
    end

endmodule

// File: rtl/skid_stage_buffer.sv
module skid_stage_buffer
    import skid_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int DEPTH       = 4,
    parameter int WIDTH       = 2,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W      = $clog2(WIDTH + 1),
    localparam int OCC_W      = $clog2(DEPTH + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [WIDTH-1:0]                  in_valid,
    input  logic [WIDTH-1:0]                  in_squashed,
    input  logic [WIDTH-1:0][TID_W-1:0]       in_tid,
    input  logic [WIDTH-1:0][SEQ_W-1:0]       in_seq,
    input  logic [WIDTH-1:0][PC_W-1:0]        in_pc,
    input  logic [CNT_W-1:0]                  local_cnt,
    input  logic [WIDTH-1:0]                  ret_valid,
    input  logic [WIDTH-1:0][TID_W-1:0]       ret_tid,
    input  logic [WIDTH-1:0][SEQ_W-1:0]       ret_seq,
    input  logic [WIDTH-1:0][PC_W-1:0]        ret_pc,
    input  logic                              sq_valid,
    input  logic [TID_W-1:0]                  sq_tid,
    input  logic [SEQ_W-1:0]                  sq_seq,
    input  logic                              pop_valid,
    input  logic [TID_W-1:0]                  pop_tid,
    input  logic [NUM_THREADS-1:0][1:0]       up_status,
    output logic [WIDTH-1:0]                  pb_valid,
    output logic [NUM_THREADS-1:0]            up_unblock,
    output logic [NUM_THREADS-1:0]            hd_valid,
    output logic [NUM_THREADS-1:0][SEQ_W-1:0] hd_seq,
    output logic [NUM_THREADS-1:0][PC_W-1:0]  hd_pc,
    output logic [NUM_THREADS-1:0][OCC_W-1:0] free_cnt,
    output logic [NUM_THREADS-1:0]            send_ok,
    output logic                              ovf_err
);

    logic [WIDTH-1:0]                  acc;
    logic [WIDTH-1:0]                  pb;
    tag_t                              in_tag  [WIDTH];
    tag_t                              ret_tag [WIDTH];
    logic [NUM_THREADS-1:0][OCC_W-1:0] occ;
    logic [NUM_THREADS-1:0]            ovf_v;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            in_tag[i].seq  = in_seq[i];
            in_tag[i].pc   = in_pc[i];
            ret_tag[i].seq = ret_seq[i];
            ret_tag[i].pc  = ret_pc[i];
        end
    end

    skid_sorter #(.WIDTH(WIDTH), .TID_W(TID_W), .CNT_W(CNT_W)) u_sort (
        .in_valid    (in_valid),
        .in_squashed (in_squashed),
        .in_tid      (in_tid),
        .in_seq      (in_seq),
        .local_cnt   (local_cnt),
        .sq_valid    (sq_valid),
        .sq_tid      (sq_tid),
        .sq_seq      (sq_seq),
        .acc         (acc),
        .pb          (pb)
    );

    assign pb_valid = pb;

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            up_unblock[t] = 1'b0;
            for (int i = 0; i < WIDTH; i++) begin
                if (pb[i] && int'(in_tid[i]) == t && may_unblock(up_status[t]))
                    up_unblock[t] = 1'b1;
            end
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [WIDTH-1:0] tail_mask;
        logic [WIDTH-1:0] ret_mask;
        tag_t             head;

        always_comb begin
            for (int i = 0; i < WIDTH; i++) begin
                tail_mask[i] = acc[i] && (in_tid[i] == TID_W'(t));
                ret_mask[i]  = ret_valid[i] && (ret_tid[i] == TID_W'(t));
            end
        end

        skid_deque #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OCC_W(OCC_W)) u_q (
            .clk        (clk),
            .rst        (rst),
            .pop        (pop_valid && pop_tid == TID_W'(t)),
            .sq_hit     (sq_valid && sq_tid == TID_W'(t)),
            .sq_seq     (sq_seq),
            .ret_mask   (ret_mask),
            .ret_tag    (ret_tag),
            .tail_mask  (tail_mask),
            .tail_tag   (in_tag),
            .head       (head),
            .head_valid (hd_valid[t]),
            .occ        (occ[t]),
            .ovf        (ovf_v[t])
        );

        assign hd_seq[t] = head.seq;
        assign hd_pc[t]  = head.pc;
    end

    skid_credit #(
        .NUM_THREADS (NUM_THREADS),
        .DEPTH       (DEPTH),
        .WIDTH       (WIDTH),
        .TID_W       (TID_W),
        .OCC_W       (OCC_W)
    ) u_cred (
        .occ      (occ),
        .in_valid (in_valid),
        .in_tid   (in_tid),
        .free_cnt (free_cnt),
        .send_ok  (send_ok)
    );

    always_ff @(posedge clk) begin
        if (rst)         ovf_err <= 1'b0;
        else if (|ovf_v) ovf_err <= 1'b1;
    end

endmodule

// File: rtl/skid_stage_checker.sv
module skid_stage_checker
    import skid_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int DEPTH       = 4,
    parameter int WIDTH       = 2,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int OCC_W      = $clog2(DEPTH + 1)
) (
    input logic                              clk,
    input logic                              rst,
    input logic [WIDTH-1:0]                  in_valid,
    input logic [WIDTH-1:0]                  in_squashed,
    input logic [WIDTH-1:0]                  pb_valid,
    input logic [NUM_THREADS-1:0]            up_unblock,
    input logic [NUM_THREADS-1:0][1:0]       up_status,
    input logic                              sq_valid,
    input logic [TID_W-1:0]                  sq_tid,
    input logic [SEQ_W-1:0]                  sq_seq,
    input logic [NUM_THREADS-1:0]            hd_valid,
    input logic [NUM_THREADS-1:0][SEQ_W-1:0] hd_seq,
    input logic [NUM_THREADS-1:0][OCC_W-1:0] free_cnt,
    input logic                              ovf_err
);

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (hd_valid == '0 && !ovf_err));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        a_r4_handback_live_only: assert property (@(posedge clk) disable iff (rst)
            pb_valid[i] |-> (in_valid[i] && !in_squashed[i]));
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        a_r5_unblock_status: assert property (@(posedge clk) disable iff (rst)
            up_unblock[t] |-> (up_status[t] == 2'd0 || up_status[t] == 2'd1));

        a_r6_squash_clears_younger: assert property (@(posedge clk) disable iff (rst)
            (sq_valid && sq_tid == TID_W'(t)) |=> (!hd_valid[t] || hd_seq[t] <= $past(sq_seq)));

        a_r10_free_bound: assert property (@(posedge clk) disable iff (rst)
            free_cnt[t] <= OCC_W'(DEPTH));
    end

endmodule

bind skid_stage_buffer skid_stage_checker #(
    .NUM_THREADS (NUM_THREADS),
    .DEPTH       (DEPTH),
    .WIDTH       (WIDTH)
) u_chk (.*);

// File: tb/tb_skid_stage_buffer.sv
`timescale 1ns/1ps
module tb_skid_stage_buffer;

    localparam int NT = 2;
    localparam int DP = 4;
    localparam int WD = 2;

    logic clk = 1'b0;
    logic rst;
    logic [WD-1:0]        in_valid, in_squashed, ret_valid;
    logic [WD-1:0][0:0]   in_tid, ret_tid;
    logic [WD-1:0][7:0]   in_seq, ret_seq;
    logic [WD-1:0][15:0]  in_pc, ret_pc;
    logic [1:0]           local_cnt;
    logic                 sq_valid;
    logic [0:0]           sq_tid;
    logic [7:0]           sq_seq;
    logic                 pop_valid;
    logic [0:0]           pop_tid;
    logic [NT-1:0][1:0]   up_status;
    logic [WD-1:0]        pb_valid;
    logic [NT-1:0]        up_unblock, hd_valid, send_ok;
    logic [NT-1:0][7:0]   hd_seq;
    logic [NT-1:0][15:0]  hd_pc;
    logic [NT-1:0][2:0]   free_cnt;
    logic                 ovf_err;

    always #2.5 clk = ~clk;

    skid_stage_buffer #(.NUM_THREADS(NT), .DEPTH(DP), .WIDTH(WD)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_squashed(in_squashed), .in_tid(in_tid),
        .in_seq(in_seq), .in_pc(in_pc), .local_cnt(local_cnt),
        .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_seq(ret_seq), .ret_pc(ret_pc),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .pop_valid(pop_valid), .pop_tid(pop_tid), .up_status(up_status),
        .pb_valid(pb_valid), .up_unblock(up_unblock), .hd_valid(hd_valid),
        .hd_seq(hd_seq), .hd_pc(hd_pc), .free_cnt(free_cnt), .send_ok(send_ok),
        .ovf_err(ovf_err)
    );

    // Scoreboard: expected queue contents per thread
    int sb_seq [NT][$];
    int sb_pc  [NT][$];
    bit sb_err;
    int n_chk;
    int n_fail;
    bit done;

    function automatic int pc_of(input int seq);
        return 16'h0100 + seq * 4;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_squashed = '0; in_tid = '0; in_seq = '0; in_pc = '0;
        ret_valid = '0; ret_tid = '0; ret_seq = '0; ret_pc = '0;
        local_cnt = '0; sq_valid = 1'b0; sq_tid = '0; sq_seq = '0;
        pop_valid = 1'b0; pop_tid = '0;
    endtask

    task automatic put_in(input int slot, input int tid, input int seq, input bit squashed);
        in_valid[slot]    = 1'b1;
        in_squashed[slot] = squashed;
        in_tid[slot]      = 1'(tid);
        in_seq[slot]      = 8'(seq);
        in_pc[slot]       = 16'(pc_of(seq));
    endtask

    task automatic put_ret(input int slot, input int tid, input int seq);
        ret_valid[slot] = 1'b1;
        ret_tid[slot]   = 1'(tid);
        ret_seq[slot]   = 8'(seq);
        ret_pc[slot]    = 16'(pc_of(seq));
    endtask

    // Driver: computes expected results of one cycle, applies the edge, monitor compares
    task automatic tick(input string req);
        int room;
        int rank;
        bit kill;
        bit ex_pb [WD];
        bit ex_acc [WD];
        int nq_seq [NT][$];
        int nq_pc  [NT][$];
        room = (int'(local_cnt) >= WD) ? 0 : WD - int'(local_cnt);
        rank = 0;
        for (int i = 0; i < WD; i++) begin
            kill = sq_valid && (in_tid[i] == sq_tid) && (in_seq[i] > sq_seq);
            ex_acc[i] = in_valid[i] && !in_squashed[i] && !kill && (rank < room);
            ex_pb[i]  = in_valid[i] && !in_squashed[i] && !kill && (rank >= room);
            if (ex_acc[i] || ex_pb[i]) rank++;
        end
        #1;
        for (int i = 0; i < WD; i++) chk("R4 handback", int'(pb_valid[i]), int'(ex_pb[i]));
        for (int t = 0; t < NT; t++) begin
            bit eu;
            int lc;
            eu = 1'b0;
            lc = 0;
            for (int i = 0; i < WD; i++) begin
                if (ex_pb[i] && int'(in_tid[i]) == t && up_status[t] <= 2'd1) eu = 1'b1;
                if (in_valid[i] && int'(in_tid[i]) == t) lc++;
            end
            chk("R5 unblock", int'(up_unblock[t]), int'(eu));
            chk("R10 send_ok", int'(send_ok[t]), int'((DP - sb_seq[t].size()) > lc));
        end
        for (int t = 0; t < NT; t++) begin
            bit sqt;
            sqt = sq_valid && int'(sq_tid) == t;
            for (int i = 0; i < WD; i++)
                if (ret_valid[i] && int'(ret_tid[i]) == t && !(sqt && int'(ret_seq[i]) > int'(sq_seq))) begin
                    nq_seq[t].push_back(int'(ret_seq[i]));
                    nq_pc[t].push_back(int'(ret_pc[i]));
                end
            for (int k = 0; k < sb_seq[t].size(); k++) begin
                if (k == 0 && pop_valid && int'(pop_tid) == t) continue;
                if (sqt && sb_seq[t][k] > int'(sq_seq)) continue;
                nq_seq[t].push_back(sb_seq[t][k]);
                nq_pc[t].push_back(sb_pc[t][k]);
            end
            for (int i = 0; i < WD; i++)
                if (ex_acc[i] && int'(in_tid[i]) == t) begin
                    nq_seq[t].push_back(int'(in_seq[i]));
                    nq_pc[t].push_back(int'(in_pc[i]));
                end
            if (nq_seq[t].size() > DP) sb_err = 1'b1;
            while (nq_seq[t].size() > DP) begin
                void'(nq_seq[t].pop_back());
                void'(nq_pc[t].pop_back());
            end
        end
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            sb_seq[t] = nq_seq[t];
            sb_pc[t]  = nq_pc[t];
        end
        @(negedge clk);
        for (int t = 0; t < NT; t++) begin
            chk(req, int'(hd_valid[t]), int'(sb_seq[t].size() > 0));
            if (sb_seq[t].size() > 0) begin
                chk(req, int'(hd_seq[t]), sb_seq[t][0]);
                chk(req, int'(hd_pc[t]), sb_pc[t][0]);
            end
            chk("R10 free", int'(free_cnt[t]), DP - sb_seq[t].size());
        end
        chk("R11 err", int'(ovf_err), int'(sb_err));
        clear_in();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        n_chk = 0; n_fail = 0; sb_err = 1'b0; done = 1'b0;
        clear_in();
        up_status = {2'd1, 2'd1};
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 hd_valid", int'(hd_valid), 0);
        chk("R1 free0", int'(free_cnt[0]), DP);
        chk("R1 free1", int'(free_cnt[1]), DP);
        chk("R1 send_ok", int'(send_ok), 3);
        chk("R1 err", int'(ovf_err), 0);
        @(negedge clk);

        // R2: two slots fill thread 0 tail in slot order
        put_in(0, 0, 1, 0); put_in(1, 0, 2, 0);
        tick("R2 accept two");

        // R4/R5: room of one, thread 0 running -> handback and unblock
        local_cnt = 2'd1; put_in(0, 0, 3, 0); put_in(1, 0, 4, 0);
        tick("R4 overflow slot");

        // R5: blocked thread gets no unblock request
        up_status[1] = 2'd2;
        local_cnt = 2'd1; put_in(0, 1, 10, 0); put_in(1, 1, 11, 0);
        tick("R5 blocked");

        // R3: squashed slot uses no room
        local_cnt = 2'd1; put_in(0, 1, 12, 1); put_in(1, 1, 13, 0);
        tick("R3 squashed dropped");

        // R9: pop thread 0 head
        pop_valid = 1'b1; pop_tid = 1'd0;
        tick("R9 pop");

        // R8: returned entries go to head, slot 0 frontmost
        put_ret(0, 0, 7); put_ret(1, 0, 8);
        tick("R8 head push");

        // R10 + R5 idle: full thread 0, latch slot waits, room zero
        up_status[0] = 2'd0;
        local_cnt = 2'd2; put_in(0, 0, 9, 0);
        tick("R10 full credit");

        // R6: squash thread 0 bound 5 keeps 2,3
        sq_valid = 1'b1; sq_tid = 1'd0; sq_seq = 8'd5;
        tick("R6 squash t0");
        pop_valid = 1'b1; pop_tid = 1'd0;
        tick("R6 drain 1");
        pop_valid = 1'b1; pop_tid = 1'd0;
        tick("R6 drain 2");
        // R9: pop on empty queue ignored
        pop_valid = 1'b1; pop_tid = 1'd0;
        tick("R9 pop empty");

        // R6 scan: thread 1 becomes 10,13,4,15 ; thread 0 gets 40
        put_in(0, 1, 4, 0); put_in(1, 1, 15, 0);
        tick("R6 build t1");
        put_in(0, 0, 40, 0);
        tick("R12 t0 entry");
        sq_valid = 1'b1; sq_tid = 1'd1; sq_seq = 8'd11;
        tick("R6 squash mid");
        chk("R12 t0 untouched", int'(hd_seq[0]), 40);

        // R7: squash and pushes for thread 0 in the same cycle
        sq_valid = 1'b1; sq_tid = 1'd0; sq_seq = 8'd20;
        local_cnt = 2'd1; put_in(0, 0, 30, 0); put_in(1, 0, 6, 0);
        put_ret(0, 0, 25);
        tick("R7 same cycle");
        chk("R12 t1 head", int'(hd_seq[1]), 10);

        // R11: thread 1 pushed past depth
        put_ret(0, 1, 1); put_ret(1, 1, 2);
        put_in(0, 1, 60, 0); put_in(1, 1, 61, 0);
        tick("R11 overflow");
        tick("R11 sticky");
        for (int k = 0; k < 4; k++) begin
            pop_valid = 1'b1; pop_tid = 1'd1;
            tick("R11 drain");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule